// File: doc/BRIEF.md
# Hardware TLB Miss Handler

This block is the hardware walker that a processor's translation unit calls when a lookup in the translation buffer misses. It takes the missing virtual page number and the kind of access (read or write) and forms the address of the page table entry from a page table base value. It fetches that entry with one read over a simple request/response memory handshake. The page table is flat, with one 32-bit word for each of the 2^26 virtual pages, so the entry address is the base plus four times the page number.

When the entry marks the page as resident, the walker writes the 4 status bits and the 22-bit frame number into the translation buffer through its refill port. It then gives a one-cycle done pulse, and the requester repeats its lookup, which now hits. When the entry marks the page as absent, nothing is written. The walker instead raises a precise page-fault exception carrying the page number and the write flag, and holds it until the operating system acknowledges it. Only one miss is handled at a time. The requester is held by a stall signal for the whole walk.

Top module: `tlb_walker`

## Requirements
- R1: After reset, stall_o, mem_req_valid_o, refill_valid_o, fault_valid_o and done_o are all low.
- R2: A miss presented while the walker is idle is accepted at that clock edge. From the next cycle, mem_req_valid_o is high and mem_req_addr_o equals ptbase_i + 4 × miss_vpn_i, taken modulo 2^32.
- R3: While mem_req_valid_o is high and mem_req_ready_i is low, the request stays high and its address stays the same.
- R4: A response is taken only in the waiting state, which starts in the cycle after the request handshake. A response pulse at any other time changes no output.
- R5: If bit 25 (present) of the response word is 1, refill_valid_o is high for exactly one cycle. In that cycle refill_vpn_o is the missing page, refill_ppn_o is response bits 21:0 and refill_flags_o is response bits 25:22. Bits 31:26 have no effect.
- R6: done_o is high for exactly one cycle, the cycle after refill_valid_o. In that cycle stall_o is already low.
- R7: If bit 25 of the response word is 0, fault_valid_o rises and stays high, with fault_vpn_o and fault_write_o holding the missing page and its write flag, until a cycle with fault_ack_i high. After that the walker is idle. Neither refill_valid_o nor done_o is raised for this miss.
- R8: stall_o is high from the cycle after a miss is accepted through the last refill or fault cycle. It is low whenever the walker is idle.
- R9: miss_valid_i is ignored while a walk is in progress. The page number and write flag reported at refill or fault are those of the accepted miss.
- R10: fault_ack_i is ignored unless a fault is being raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid_i | input | 1 | A translation miss is presented |
| miss_vpn_i | input | 26 | Virtual page number that missed |
| miss_write_i | input | 1 | The missing access is a store |
| ptbase_i | input | 32 | Byte address of the page table |
| stall_o | output | 1 | Requester must hold while a walk runs |
| mem_req_valid_o | output | 1 | Page table read request |
| mem_req_addr_o | output | 32 | Byte address of the entry being read |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_rsp_valid_i | input | 1 | Read data is valid |
| mem_rsp_data_i | input | 32 | Page table word read |
| refill_valid_o | output | 1 | Write one mapping into the translation buffer |
| refill_vpn_o | output | 26 | Page number of the mapping |
| refill_ppn_o | output | 22 | Physical frame number of the mapping |
| refill_flags_o | output | 4 | Status bits {present, writable, user, dirty} |
| done_o | output | 1 | Pulse: repeat the lookup |
| fault_valid_o | output | 1 | Page-fault exception raised |
| fault_vpn_o | output | 26 | Faulting virtual page number |
| fault_write_o | output | 1 | The faulting access was a store |
| fault_ack_i | input | 1 | Operating system takes the fault |

## Verification
The bench targets the following corner cases:
- Table bases near the top of the address space, where the entry address must wrap. A design that carried or truncated wrongly would read the wrong word.
- Memory that holds off the request for several cycles. A design that dropped or changed the request would lose the walk.
- Stray response and acknowledge pulses outside their states, and new miss requests during a walk. A design that acted on these would refill or fault with a wrong page, or leave a fault early.
- Entries with garbage in the top bits and with each present value. A design that decoded the wrong bit would refill absent pages or fault on resident ones.

// File: rtl/tlbw_pkg.sv
package tlbw_pkg;
    localparam int VPN_W_DEF   = 26;
    localparam int PPN_W_DEF   = 22;
    localparam int FLAG_W_DEF  = 4;
    localparam int ADDR_W_DEF  = 32;
    localparam int WORD_W_DEF  = 32;
    localparam int PTE_BYTES_DEF = 4;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_REQ    = 3'd1,
        ST_WAIT   = 3'd2,
        ST_REFILL = 3'd3,
        ST_FAULT  = 3'd4
    } walk_state_e;
endpackage

// File: rtl/tlbw_pte_addr.sv
module tlbw_pte_addr #(
    parameter int VPN_W     = tlbw_pkg::VPN_W_DEF,
    parameter int ADDR_W    = tlbw_pkg::ADDR_W_DEF,
    parameter int PTE_BYTES = tlbw_pkg::PTE_BYTES_DEF
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [VPN_W-1:0]  vpn_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int SHIFT = $clog2(PTE_BYTES);
    localparam int OFS_W = VPN_W + SHIFT;

    logic [OFS_W-1:0] ofs;
    assign ofs = {vpn_i, {SHIFT{1'b0}}};

    // Byte offset of the entry, fitted to the address width (wraps modulo 2^ADDR_W)
    generate
        if (ADDR_W > OFS_W) begin : g_extend
            assign addr_o = base_i + {{(ADDR_W-OFS_W){1'b0}}, ofs};
        end else if (ADDR_W == OFS_W) begin : g_exact
            assign addr_o = base_i + ofs;
        end else begin : g_trunc
            assign addr_o = base_i + ofs[ADDR_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/tlbw_pte_unpack.sv
module tlbw_pte_unpack #(
    parameter int PPN_W  = tlbw_pkg::PPN_W_DEF,
    parameter int FLAG_W = tlbw_pkg::FLAG_W_DEF
) (
    input  logic [FLAG_W+PPN_W-1:0] pte_i,
    output logic                    present_o,
    output logic [FLAG_W-1:0]       flags_o,
    output logic [PPN_W-1:0]        ppn_o
);
    // Status bits sit directly above the frame number; the top status bit marks residency
    assign flags_o   = pte_i[FLAG_W+PPN_W-1:PPN_W];
    assign ppn_o     = pte_i[PPN_W-1:0];
    assign present_o = flags_o[FLAG_W-1];
endmodule

// File: rtl/tlb_walker.sv
module tlb_walker
    import tlbw_pkg::*;
#(
    parameter int VPN_W     = VPN_W_DEF,
    parameter int PPN_W     = PPN_W_DEF,
    parameter int FLAG_W    = FLAG_W_DEF,
    parameter int ADDR_W    = ADDR_W_DEF,
    parameter int WORD_W    = WORD_W_DEF,
    parameter int PTE_BYTES = PTE_BYTES_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid_i,
    input  logic [VPN_W-1:0]  miss_vpn_i,
    input  logic              miss_write_i,
    input  logic [ADDR_W-1:0] ptbase_i,
    output logic              stall_o,
    output logic              mem_req_valid_o,
    output logic [ADDR_W-1:0] mem_req_addr_o,
    input  logic              mem_req_ready_i,
    input  logic              mem_rsp_valid_i,
    input  logic [WORD_W-1:0] mem_rsp_data_i,
    output logic              refill_valid_o,
    output logic [VPN_W-1:0]  refill_vpn_o,
    output logic [PPN_W-1:0]  refill_ppn_o,
    output logic [FLAG_W-1:0] refill_flags_o,
    output logic              done_o,
    output logic              fault_valid_o,
    output logic [VPN_W-1:0]  fault_vpn_o,
    output logic              fault_write_o,
    input  logic              fault_ack_i
);
    localparam int PTE_W = FLAG_W + PPN_W;

    typedef struct packed {
        walk_state_e       st;
        logic [VPN_W-1:0]  vpn;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [PTE_W-1:0]  pte;
        logic              done;
    } walk_regs_t;

    walk_regs_t r_d, r_q;

    logic [ADDR_W-1:0] pte_addr;
    logic              rsp_present;
    logic [FLAG_W-1:0] rsp_flags;
    logic [PPN_W-1:0]  rsp_ppn;
    logic [FLAG_W-1:0] held_flags;
    logic [PPN_W-1:0]  held_ppn;
    logic              held_present;

    tlbw_pte_addr #(
        .VPN_W    (VPN_W),
        .ADDR_W   (ADDR_W),
        .PTE_BYTES(PTE_BYTES)
    ) addr_i (
        .base_i(ptbase_i),
        .vpn_i (miss_vpn_i),
        .addr_o(pte_addr)
    );

    tlbw_pte_unpack #(
        .PPN_W (PPN_W),
        .FLAG_W(FLAG_W)
    ) rsp_unpack_i (
        .pte_i    (mem_rsp_data_i[PTE_W-1:0]),
        .present_o(rsp_present),
        .flags_o  (rsp_flags),
        .ppn_o    (rsp_ppn)
    );

    tlbw_pte_unpack #(
        .PPN_W (PPN_W),
        .FLAG_W(FLAG_W)
    ) held_unpack_i (
        .pte_i    (r_q.pte),
        .present_o(held_present),
        .flags_o  (held_flags),
        .ppn_o    (held_ppn)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (miss_valid_i) begin
                    r_d.st   = ST_REQ;
                    r_d.vpn  = miss_vpn_i;
                    r_d.wr   = miss_write_i;
                    r_d.addr = pte_addr;
                end
            end
            ST_REQ: begin
                if (mem_req_ready_i) begin
                    r_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid_i) begin
                    r_d.pte = {rsp_flags, rsp_ppn};
                    r_d.st  = rsp_present ? ST_REFILL : ST_FAULT;
                end
            end
            ST_REFILL: begin
                r_d.st   = ST_IDLE;
                r_d.done = 1'b1;
            end
            ST_FAULT: begin
                if (fault_ack_i) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, vpn: '0, wr: 1'b0, addr: '0, pte: '0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign stall_o         = (r_q.st != ST_IDLE);
    assign mem_req_valid_o = (r_q.st == ST_REQ);
    assign mem_req_addr_o  = r_q.addr;
    assign refill_valid_o  = (r_q.st == ST_REFILL);
    assign refill_vpn_o    = r_q.vpn;
    assign refill_ppn_o    = held_ppn;
    assign refill_flags_o  = held_flags;
    assign done_o          = r_q.done;
    assign fault_valid_o   = (r_q.st == ST_FAULT);
    assign fault_vpn_o     = r_q.vpn;
    assign fault_write_o   = r_q.wr;

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req_valid_o, refill_valid_o, fault_valid_o})); // R8
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o))); // R3
    AST_REFILL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        refill_valid_o |=> (!refill_valid_o && done_o && !stall_o)); // R6
    AST_REFILL_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        refill_valid_o |-> held_present); // R5
    AST_FAULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid_o && !fault_ack_i) |=> (fault_valid_o && $stable(fault_vpn_o) && $stable(fault_write_o))); // R7
    AST_FAULT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid_o |=> !done_o); // R7
    AST_BUSY_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o || refill_valid_o || fault_valid_o) |-> stall_o); // R8
    AST_DONE_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!stall_o && $past(refill_valid_o))); // R6
endmodule

// File: tb/tlb_walker_tb.sv
module tlb_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_valid_i = 1'b0;
    logic [25:0] miss_vpn_i = '0;
    logic        miss_write_i = 1'b0;
    logic [31:0] ptbase_i = '0;
    logic        stall_o;
    logic        mem_req_valid_o;
    logic [31:0] mem_req_addr_o;
    logic        mem_req_ready_i = 1'b0;
    logic        mem_rsp_valid_i = 1'b0;
    logic [31:0] mem_rsp_data_i = '0;
    logic        refill_valid_o;
    logic [25:0] refill_vpn_o;
    logic [21:0] refill_ppn_o;
    logic [3:0]  refill_flags_o;
    logic        done_o;
    logic        fault_valid_o;
    logic [25:0] fault_vpn_o;
    logic        fault_write_o;
    logic        fault_ack_i = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    tlb_walker dut_i (
        .clk(clk), .rst_n(rst_n),
        .miss_valid_i(miss_valid_i), .miss_vpn_i(miss_vpn_i), .miss_write_i(miss_write_i),
        .ptbase_i(ptbase_i), .stall_o(stall_o),
        .mem_req_valid_o(mem_req_valid_o), .mem_req_addr_o(mem_req_addr_o),
        .mem_req_ready_i(mem_req_ready_i),
        .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_data_i(mem_rsp_data_i),
        .refill_valid_o(refill_valid_o), .refill_vpn_o(refill_vpn_o),
        .refill_ppn_o(refill_ppn_o), .refill_flags_o(refill_flags_o),
        .done_o(done_o), .fault_valid_o(fault_valid_o), .fault_vpn_o(fault_vpn_o),
        .fault_write_o(fault_write_o), .fault_ack_i(fault_ack_i)
    );

    function automatic logic [31:0] exp_addr(input logic [31:0] base, input logic [25:0] vpn);
        return base + {4'b0, vpn, 2'b00};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // One full walk; noise drives stray inputs that must be ignored
    task automatic walk(input logic [31:0] base, input logic [25:0] vpn, input logic wr,
                        input logic [31:0] pte, input int rdy_dly, input int rsp_dly,
                        input int ack_dly, input logic noise);
        logic [31:0] ea;
        ea = exp_addr(base, vpn);
        ptbase_i     = base;
        miss_valid_i = 1'b1;
        miss_vpn_i   = vpn;
        miss_write_i = wr;
        step();
        miss_valid_i = noise;
        miss_vpn_i   = ~vpn;
        miss_write_i = ~wr;
        check("R2 req valid", mem_req_valid_o, 1);
        check("R2 req addr", mem_req_addr_o, ea);
        check("R8 stall on req", stall_o, 1);
        for (int i = 0; i < rdy_dly; i++) begin
            mem_rsp_valid_i = noise;
            mem_rsp_data_i  = 32'h0200_0000;
            step();
            mem_rsp_valid_i = 1'b0;
            check("R3 req held", mem_req_valid_o, 1);
            check("R3 addr held", mem_req_addr_o, ea);
            check("R4 early rsp ignored", {refill_valid_o, fault_valid_o}, 0);
        end
        mem_req_ready_i = 1'b1;
        step();
        mem_req_ready_i = 1'b0;
        for (int i = 0; i < rsp_dly; i++) begin
            step();
            check("R4 waiting", {stall_o, mem_req_valid_o, refill_valid_o, fault_valid_o}, 4'b1000);
        end
        mem_rsp_valid_i = 1'b1;
        mem_rsp_data_i  = pte;
        step();
        mem_rsp_valid_i = 1'b0;
        if (pte[25]) begin
            check("R5 refill valid", refill_valid_o, 1);
            check("R5 refill vpn R9", refill_vpn_o, vpn);
            check("R5 refill ppn", refill_ppn_o, pte[21:0]);
            check("R5 refill flags", refill_flags_o, pte[25:22]);
            check("R8 stall at refill", stall_o, 1);
            check("R6 no early done", done_o, 0);
            step();
            check("R6 done pulse", done_o, 1);
            check("R6 stall released", stall_o, 0);
            check("R5 refill one cycle", refill_valid_o, 0);
            miss_valid_i = 1'b0;
            step();
            check("R6 done one cycle", done_o, 0);
        end else begin
            check("R7 fault raised", fault_valid_o, 1);
            check("R7 fault vpn R9", fault_vpn_o, vpn);
            check("R7 fault write", fault_write_o, wr);
            check("R7 no refill", refill_valid_o, 0);
            for (int i = 0; i < ack_dly; i++) begin
                step();
                check("R7 fault held", {fault_valid_o, stall_o, fault_vpn_o, fault_write_o},
                      {2'b11, vpn, wr});
            end
            miss_valid_i = 1'b0;
            fault_ack_i  = 1'b1;
            step();
            fault_ack_i = 1'b0;
            check("R7 fault cleared", {fault_valid_o, stall_o, done_o}, 0);
        end
        miss_valid_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0C4B));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset outputs",
              {stall_o, mem_req_valid_o, refill_valid_o, fault_valid_o, done_o}, 0);

        // R4, R10: stray response and acknowledge while idle
        mem_rsp_valid_i = 1'b1;
        mem_rsp_data_i  = 32'h02AB_CDEF;
        fault_ack_i     = 1'b1;
        step();
        mem_rsp_valid_i = 1'b0;
        fault_ack_i     = 1'b0;
        check("R4 R10 idle strays ignored",
              {stall_o, mem_req_valid_o, refill_valid_o, fault_valid_o, done_o}, 0);

        // Directed corners
        walk(32'hFFFF_FFF0, 26'd5, 1'b0, 32'hFC00_0000 | 32'h0200_0000 | 22'h3F_FFFF, 0, 0, 0, 1'b0);
        walk(32'h0000_1000, 26'h3FF_FFFF, 1'b1, 32'h03FF_FFFF, 3, 2, 0, 1'b1);
        walk(32'h8000_0000, 26'd0, 1'b1, 32'hFDFF_FFFF, 1, 0, 4, 1'b1);
        walk(32'h1234_5678, 26'h155_5555, 1'b0, 32'h0000_0000, 0, 3, 0, 1'b0);

        // R10: acknowledge during a walk must not cut it short
        ptbase_i = 32'h4000_0000;
        miss_valid_i = 1'b1;
        miss_vpn_i = 26'd9;
        step();
        miss_valid_i = 1'b0;
        fault_ack_i = 1'b1;
        step();
        fault_ack_i = 1'b0;
        check("R10 ack in request ignored", {mem_req_valid_o, stall_o}, 2'b11);
        mem_req_ready_i = 1'b1;
        step();
        mem_req_ready_i = 1'b0;
        mem_rsp_valid_i = 1'b1;
        mem_rsp_data_i  = 32'h0000_0042;
        step();
        mem_rsp_valid_i = 1'b0;
        check("R7 fault for absent", fault_valid_o, 1);
        fault_ack_i = 1'b1;
        step();
        fault_ack_i = 1'b0;
        check("R7 fault released", {fault_valid_o, stall_o}, 0);

        // Random walks
        for (int k = 0; k < 60; k++) begin
            logic [31:0] b;
            logic [31:0] p;
            b = $urandom();
            p = $urandom();
            walk(b, 26'($urandom()), 1'($urandom()), p,
                 int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                 int'($urandom_range(0, 3)), 1'($urandom()));
        end
        finish_run();
    end
endmodule